// File: doc/BRIEF.md
# Host Command Decoder with Status Reply

This block sits between a byte-wide host link and the control logic of an I/Q drive channel. It reads a stream of messages. Each message begins with a one-byte command code, followed by a payload whose length is fixed by that code. The decoder holds four 16-bit calibration words: I offset, I gain, Q offset and Q gain. It also holds a test/operate mode bit and a sticky error flag.

Two commands have no register of their own. A waveform-table load passes its payload bytes straight to a table write port. An amplitude/phase correction is delivered as a one-cycle strobe. A readback command raises a one-cycle request toward the table logic. A status command makes the block return a 12-byte reply on an outbound byte stream.

The parser is a three-state machine:
- `P_IDLE` waits for a code byte. It moves to `P_PAYLOAD` for a known code that has a payload, straight to `P_COMMIT` for a known code without a payload, and stays in `P_IDLE` for an unknown code.
- `P_PAYLOAD` counts payload bytes and moves to `P_COMMIT` on the last one.
- `P_COMMIT` lasts one cycle. It applies the command and then returns to `P_IDLE`.

The reply serializer has two states. `T_IDLE` waits for a status commit, and at that point captures a snapshot and moves to `T_SEND`. `T_SEND` presents the bytes one at a time and returns to `T_IDLE` after the twelfth byte is taken.

Top module: `hostcmd_decoder`

## Requirements
- R1: After reset the four calibration words read 0, `test_mode` and `cmd_err` are 0, `tx_valid` is 0 and `rx_ready` is 1.
- R2: Codes 4, 5, 6 and 7 take a 2-byte payload, sent most significant byte first, into I offset, I gain, Q offset and Q gain respectively.
- R3: A register changes only after the last payload byte of its command has been accepted, and the new value appears two clock edges after that byte's handshake. A partial payload leaves every register unchanged.
- R4: Code 8 (no payload) sets `test_mode` to 1, and code 9 (no payload) clears it to 0.
- R5: Code 3 takes 4 payload bytes and then raises `corr_valid` for exactly one cycle. At that point `corr_amp` holds the first two bytes and `corr_phase` holds the last two, each most significant byte first.
- R6: Code 1 takes 2048 payload bytes. Each byte appears on `tbl_wr_data` with `tbl_wr_en` high, at addresses 0 through 2047 in order. None of these bytes is decoded as a command. `tbl_load_done` then pulses once.
- R7: Code 10 (no payload) raises `rdbk_req` for exactly one cycle.
- R8: Code 2 (no payload) produces 12 reply bytes in this order:
  - byte 0: flags, with bit 0 = test mode and bit 1 = error flag, other bits 0;
  - byte 1: `trig_status`;
  - bytes 2 to 9: I offset, I gain, Q offset and Q gain, each high byte first;
  - bytes 10 and 11: `psu_level`, high byte first.
- R9: A reply byte stays on `tx_data`, with `tx_valid` held high, until `tx_ready` takes it. `rx_ready` stays low while any reply byte is outstanding.
- R10: Any code outside 1 to 10 (0 and 11 to 255) is consumed alone and the following byte is parsed as a new command. `cmd_err` is set and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data | input | 8 | Inbound byte |
| rx_valid | input | 1 | Inbound byte valid |
| rx_ready | output | 1 | Decoder accepts the inbound byte |
| tx_data | output | 8 | Reply byte |
| tx_valid | output | 1 | Reply byte valid |
| tx_ready | input | 1 | Receiver accepts the reply byte |
| trig_status | input | 8 | Trigger status reported in reply byte 1 |
| psu_level | input | 16 | Supply reading reported in reply bytes 10 and 11 |
| i_offset | output | 16 | I offset calibration word |
| i_gain | output | 16 | I gain calibration word |
| q_offset | output | 16 | Q offset calibration word |
| q_gain | output | 16 | Q gain calibration word |
| test_mode | output | 1 | 1 = test mode, 0 = operate mode |
| cmd_err | output | 1 | Sticky unknown-code flag |
| corr_valid | output | 1 | One-cycle correction strobe |
| corr_amp | output | 16 | Amplitude correction value |
| corr_phase | output | 16 | Phase correction value |
| rdbk_req | output | 1 | One-cycle table readback request |
| tbl_wr_en | output | 1 | Table byte write enable |
| tbl_wr_addr | output | 11 | Table byte address |
| tbl_wr_data | output | 8 | Table byte data |
| tbl_load_done | output | 1 | One-cycle pulse after a full table load |

## Verification
The assertions assume that the host holds `rx_data` steady while `rx_valid` is high and not yet accepted. They also assume that `trig_status` and `psu_level` do not change in the cycle a status reply is captured.

The bench drives every byte at a falling edge and keeps it until the rising edge that accepts it. It changes the status inputs only while the parser is idle. It also holds `tx_ready` low for several cycles during a reply, so the hold and stall rules are exercised under backpressure.

// File: rtl/hostcmd_pkg.sv
package hostcmd_pkg;

    localparam int BYTE_W       = 8;
    localparam int WORD_W       = 16;
    localparam int PAYLOAD_W    = 32;
    localparam int STATUS_BYTES = 12;

    typedef enum logic [7:0] {
        OP_LOAD     = 8'd1,
        OP_STATUS   = 8'd2,
        OP_CORR     = 8'd3,
        OP_SET_IOFS = 8'd4,
        OP_SET_IGN  = 8'd5,
        OP_SET_QOFS = 8'd6,
        OP_SET_QGN  = 8'd7,
        OP_TEST     = 8'd8,
        OP_OPERATE  = 8'd9,
        OP_READBACK = 8'd10
    } opcode_e;

    typedef enum logic [1:0] {
        P_IDLE    = 2'd0,
        P_PAYLOAD = 2'd1,
        P_COMMIT  = 2'd2
    } pstate_e;

    typedef enum logic {
        T_IDLE = 1'b0,
        T_SEND = 1'b1
    } tstate_e;

    function automatic logic is_known(input logic [7:0] c);
        return (c >= 8'd1) && (c <= 8'd10);
    endfunction

endpackage

// File: rtl/hostcmd_parser.sv
module hostcmd_parser
    import hostcmd_pkg::*;
#(
    parameter int TABLE_BYTES = 2048,
    localparam int CNT_W  = $clog2(TABLE_BYTES + 1),
    localparam int ADDR_W = $clog2(TABLE_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [BYTE_W-1:0]    rx_data,
    input  logic                 rx_valid,
    output logic                 rx_ready,
    input  logic                 tx_busy,
    output logic                 tbl_wr_en,
    output logic [ADDR_W-1:0]    tbl_wr_addr,
    output logic [BYTE_W-1:0]    tbl_wr_data,
    output logic                 commit,
    output logic [7:0]           commit_code,
    output logic [PAYLOAD_W-1:0] payload,
    output logic                 bad_code,
    output logic                 status_go
);

    pstate_e              state_q, state_d;
    logic [7:0]           code_q;
    logic [CNT_W-1:0]     cnt_q;
    logic [PAYLOAD_W-1:0] sh_q;
    logic                 accept;
    logic [CNT_W-1:0]     plen_in;
    logic [CNT_W-1:0]     plen_cur;

    function automatic logic [CNT_W-1:0] payload_len(input logic [7:0] c);
        logic [CNT_W-1:0] n;
        unique case (c)
            OP_LOAD:     n = CNT_W'(TABLE_BYTES);
            OP_CORR:     n = CNT_W'(4);
            OP_SET_IOFS,
            OP_SET_IGN,
            OP_SET_QOFS,
            OP_SET_QGN:  n = CNT_W'(2);
            default:     n = '0;
        endcase
        return n;
    endfunction

    assign accept   = rx_valid && rx_ready;
    assign plen_in  = payload_len(rx_data);
    assign plen_cur = payload_len(code_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= P_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            P_IDLE: begin
                if (accept && is_known(rx_data)) begin
                    if (plen_in == '0) state_d = P_COMMIT;
                    else               state_d = P_PAYLOAD;
                end
            end
            P_PAYLOAD: begin
                if (accept && (cnt_q == plen_cur - CNT_W'(1)))
                    state_d = P_COMMIT;
            end
            P_COMMIT: state_d = P_IDLE;
            default:  state_d = P_IDLE;
        endcase
    end

    // code, byte counter and payload shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            cnt_q  <= '0;
            sh_q   <= '0;
        end else if (accept) begin
            if (state_q == P_IDLE) begin
                code_q <= rx_data;
                cnt_q  <= '0;
            end else if (state_q == P_PAYLOAD) begin
                cnt_q <= cnt_q + CNT_W'(1);
                if (code_q != OP_LOAD)
                    sh_q <= {sh_q[PAYLOAD_W-BYTE_W-1:0], rx_data};
            end
        end
    end

    // outputs
    always_comb begin
        rx_ready    = ((state_q == P_IDLE) && !tx_busy) || (state_q == P_PAYLOAD);
        tbl_wr_en   = (state_q == P_PAYLOAD) && (code_q == OP_LOAD) && accept;
        tbl_wr_addr = cnt_q[ADDR_W-1:0];
        tbl_wr_data = rx_data;
        commit      = (state_q == P_COMMIT);
        commit_code = code_q;
        payload     = sh_q;
        bad_code    = (state_q == P_IDLE) && accept && !is_known(rx_data);
        status_go   = (state_q == P_COMMIT) && (code_q == OP_STATUS);
    end

endmodule

// File: rtl/hostcmd_regs.sv
module hostcmd_regs
    import hostcmd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 commit,
    input  logic [7:0]           commit_code,
    input  logic [PAYLOAD_W-1:0] payload,
    input  logic                 bad_code,
    output logic [WORD_W-1:0]    i_offset,
    output logic [WORD_W-1:0]    i_gain,
    output logic [WORD_W-1:0]    q_offset,
    output logic [WORD_W-1:0]    q_gain,
    output logic                 test_mode,
    output logic                 err_flag,
    output logic                 corr_valid,
    output logic [WORD_W-1:0]    corr_amp,
    output logic [WORD_W-1:0]    corr_phase,
    output logic                 rdbk_req,
    output logic                 load_done
);

    logic [WORD_W-1:0] low_word;
    assign low_word = payload[WORD_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            i_offset   <= '0;
            i_gain     <= '0;
            q_offset   <= '0;
            q_gain     <= '0;
            test_mode  <= 1'b0;
            err_flag   <= 1'b0;
            corr_valid <= 1'b0;
            corr_amp   <= '0;
            corr_phase <= '0;
            rdbk_req   <= 1'b0;
            load_done  <= 1'b0;
        end else begin
            corr_valid <= 1'b0;
            rdbk_req   <= 1'b0;
            load_done  <= 1'b0;
            if (bad_code) err_flag <= 1'b1;
            if (commit) begin
                unique case (commit_code)
                    OP_LOAD:     load_done <= 1'b1;
                    OP_CORR: begin
                        corr_valid <= 1'b1;
                        corr_amp   <= payload[PAYLOAD_W-1:WORD_W];
                        corr_phase <= low_word;
                    end
                    OP_SET_IOFS: i_offset  <= low_word;
                    OP_SET_IGN:  i_gain    <= low_word;
                    OP_SET_QOFS: q_offset  <= low_word;
                    OP_SET_QGN:  q_gain    <= low_word;
                    OP_TEST:     test_mode <= 1'b1;
                    OP_OPERATE:  test_mode <= 1'b0;
                    OP_READBACK: rdbk_req  <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/hostcmd_status_tx.sv
module hostcmd_status_tx
    import hostcmd_pkg::*;
#(
    parameter int NBYTES = STATUS_BYTES,
    localparam int IDX_W = $clog2(NBYTES),
    localparam int BUF_W = NBYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [BUF_W-1:0]  snapshot,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    output logic              busy
);

    tstate_e          state_q, state_d;
    logic [BUF_W-1:0] buf_q;
    logic [IDX_W-1:0] idx_q;
    logic             last;

    assign last = (idx_q == IDX_W'(NBYTES - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= T_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            T_IDLE: if (go) state_d = T_SEND;
            T_SEND: if (tx_ready && last) state_d = T_IDLE;
            default: state_d = T_IDLE;
        endcase
    end

    // snapshot shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
            idx_q <= '0;
        end else if (state_q == T_IDLE) begin
            if (go) begin
                buf_q <= snapshot;
                idx_q <= '0;
            end
        end else if (tx_ready) begin
            buf_q <= {buf_q[BUF_W-BYTE_W-1:0], {BYTE_W{1'b0}}};
            idx_q <= idx_q + IDX_W'(1);
        end
    end

    // outputs
    always_comb begin
        tx_valid = (state_q == T_SEND);
        busy     = (state_q == T_SEND);
        tx_data  = buf_q[BUF_W-1 -: BYTE_W];
    end

endmodule

// File: rtl/hostcmd_decoder.sv
module hostcmd_decoder
    import hostcmd_pkg::*;
#(
    parameter int TABLE_BYTES = 2048,
    localparam int ADDR_W = $clog2(TABLE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        rx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    input  logic [7:0]        trig_status,
    input  logic [15:0]       psu_level,
    output logic [15:0]       i_offset,
    output logic [15:0]       i_gain,
    output logic [15:0]       q_offset,
    output logic [15:0]       q_gain,
    output logic              test_mode,
    output logic              cmd_err,
    output logic              corr_valid,
    output logic [15:0]       corr_amp,
    output logic [15:0]       corr_phase,
    output logic              rdbk_req,
    output logic              tbl_wr_en,
    output logic [ADDR_W-1:0] tbl_wr_addr,
    output logic [7:0]        tbl_wr_data,
    output logic              tbl_load_done
);

    localparam int FLAG_PAD = BYTE_W - 2;

    logic                         tx_busy;
    logic                         commit;
    logic [7:0]                   commit_code;
    logic [PAYLOAD_W-1:0]         payload;
    logic                         bad_code;
    logic                         status_go;
    logic [STATUS_BYTES*BYTE_W-1:0] snapshot;

    hostcmd_parser #(.TABLE_BYTES(TABLE_BYTES)) u_parser (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .rx_ready   (rx_ready),
        .tx_busy    (tx_busy),
        .tbl_wr_en  (tbl_wr_en),
        .tbl_wr_addr(tbl_wr_addr),
        .tbl_wr_data(tbl_wr_data),
        .commit     (commit),
        .commit_code(commit_code),
        .payload    (payload),
        .bad_code   (bad_code),
        .status_go  (status_go)
    );

    hostcmd_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .commit_code(commit_code),
        .payload    (payload),
        .bad_code   (bad_code),
        .i_offset   (i_offset),
        .i_gain     (i_gain),
        .q_offset   (q_offset),
        .q_gain     (q_gain),
        .test_mode  (test_mode),
        .err_flag   (cmd_err),
        .corr_valid (corr_valid),
        .corr_amp   (corr_amp),
        .corr_phase (corr_phase),
        .rdbk_req   (rdbk_req),
        .load_done  (tbl_load_done)
    );

    assign snapshot = {{FLAG_PAD{1'b0}}, cmd_err, test_mode, trig_status,
                       i_offset, i_gain, q_offset, q_gain, psu_level};

    hostcmd_status_tx #(.NBYTES(STATUS_BYTES)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (status_go),
        .snapshot(snapshot),
        .tx_ready(tx_ready),
        .tx_valid(tx_valid),
        .tx_data (tx_data),
        .busy    (tx_busy)
    );

endmodule

// File: rtl/hostcmd_chk.sv
module hostcmd_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        rx_valid,
    input logic        rx_ready,
    input logic [7:0]  tx_data,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic [15:0] i_offset,
    input logic [15:0] i_gain,
    input logic [15:0] q_offset,
    input logic [15:0] q_gain,
    input logic        test_mode,
    input logic        cmd_err,
    input logic        corr_valid,
    input logic        rdbk_req,
    input logic        tbl_wr_en
);

    // R9
    stall_while_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !rx_ready);

    // R9
    reply_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R3
    cal_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({i_offset, i_gain, q_offset, q_gain}) |-> $past(!rx_ready));

    // R4
    mode_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(test_mode) |-> $past(!rx_ready));

    // R5
    corr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        corr_valid |=> !corr_valid);

    // R7
    rdbk_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdbk_req |=> !rdbk_req);

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |=> cmd_err);

    // R6
    tbl_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_wr_en |-> (rx_valid && rx_ready));

endmodule

bind hostcmd_decoder hostcmd_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .tx_data   (tx_data),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .i_offset  (i_offset),
    .i_gain    (i_gain),
    .q_offset  (q_offset),
    .q_gain    (q_gain),
    .test_mode (test_mode),
    .cmd_err   (cmd_err),
    .corr_valid(corr_valid),
    .rdbk_req  (rdbk_req),
    .tbl_wr_en (tbl_wr_en)
);

// File: tb/hostcmd_decoder_bench.sv
module hostcmd_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [7:0]  trig_status = '0;
    logic [15:0] psu_level = '0;
    logic [15:0] i_offset, i_gain, q_offset, q_gain;
    logic        test_mode, cmd_err, corr_valid, rdbk_req;
    logic [15:0] corr_amp, corr_phase;
    logic        tbl_wr_en, tbl_load_done;
    logic [10:0] tbl_wr_addr;
    logic [7:0]  tbl_wr_data;

    always #5 clk = ~clk;

    hostcmd_decoder u_hostcmd_decoder (.*);

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    int corr_cnt = 0, rdbk_cnt = 0, done_cnt = 0, wr_cnt = 0, wr_bad = 0;
    logic [15:0] cap_amp, cap_phase;

    // code, payload, payload length, register select, expected value
    localparam int NV = 8;
    localparam logic [61:0] VEC [NV] = '{
        {8'd4, 32'h0000BEEF, 3'd2, 3'd0, 16'hBEEF},
        {8'd5, 32'h00001357, 3'd2, 3'd1, 16'h1357},
        {8'd6, 32'h00008001, 3'd2, 3'd2, 16'h8001},
        {8'd7, 32'h000000FF, 3'd2, 3'd3, 16'h00FF},
        {8'd8, 32'h00000000, 3'd0, 3'd4, 16'h0001},
        {8'd4, 32'h00000000, 3'd2, 3'd0, 16'h0000},
        {8'd9, 32'h00000000, 3'd0, 3'd4, 16'h0000},
        {8'd7, 32'h0000FFFF, 3'd2, 3'd3, 16'hFFFF}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        rx_data  = b;
        rx_valid = 1'b1;
        while (!rx_ready) @(negedge clk);
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] pick(input logic [2:0] sel);
        case (sel)
            3'd0: return i_offset;
            3'd1: return i_gain;
            3'd2: return q_offset;
            3'd3: return q_gain;
            3'd4: return {15'd0, test_mode};
            default: return {15'd0, cmd_err};
        endcase
    endfunction

    // monitors, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (corr_valid) begin
                corr_cnt++;
                cap_amp   = corr_amp;
                cap_phase = corr_phase;
            end
            if (rdbk_req) rdbk_cnt++;
            if (tbl_load_done) done_cnt++;
            if (tbl_wr_en) begin
                if (tbl_wr_addr !== 11'(wr_cnt) || tbl_wr_data !== 8'((wr_cnt * 7 + 3) & 255))
                    wr_bad++;
                wr_cnt++;
            end
        end
    end

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        logic [7:0] exp_reply [12];
        logic [7:0] got;
        idle(3);
        // R1: reset state
        check("R1 i_offset", 32'(i_offset), 0);
        check("R1 q_gain", 32'(q_gain), 0);
        check("R1 test_mode", 32'(test_mode), 0);
        check("R1 cmd_err", 32'(cmd_err), 0);
        check("R1 tx_valid", 32'(tx_valid), 0);
        rst_n = 1'b1;
        idle(2);
        check("R1 rx_ready", 32'(rx_ready), 1);

        // R2 / R4: register and mode vectors
        for (int v = 0; v < NV; v++) begin
            send_byte(VEC[v][61:54]);
            for (int k = int'(VEC[v][21:19]) - 1; k >= 0; k--)
                send_byte(VEC[v][53:22] >> (8 * k));
            idle(3);
            check((VEC[v][18:16] == 3'd4) ? "R4 mode" : "R2 register",
                  32'(pick(VEC[v][18:16])), 32'(VEC[v][15:0]));
        end

        // R3: partial payload has no effect
        send_byte(8'd5);
        send_byte(8'hAB);
        idle(5);
        check("R3 partial i_gain", 32'(i_gain), 32'h1357);
        send_byte(8'hCD);
        check("R3 one edge after last byte", 32'(i_gain), 32'h1357);
        idle(1);
        check("R3 two edges after last byte", 32'(i_gain), 32'hABCD);

        // R5: correction strobe
        send_byte(8'd3);
        send_byte(8'h11); send_byte(8'h22); send_byte(8'h33); send_byte(8'h44);
        idle(4);
        check("R5 corr count", 32'(corr_cnt), 1);
        check("R5 corr_amp", 32'(cap_amp), 32'h1122);
        check("R5 corr_phase", 32'(cap_phase), 32'h3344);

        // R7: readback request
        send_byte(8'd10);
        idle(4);
        check("R7 rdbk count", 32'(rdbk_cnt), 1);

        // R10: unknown codes
        send_byte(8'd11);
        send_byte(8'd4); send_byte(8'h12); send_byte(8'h34);
        idle(3);
        check("R10 next byte is a command", 32'(i_offset), 32'h1234);
        check("R10 cmd_err set", 32'(cmd_err), 1);
        send_byte(8'd0);
        send_byte(8'd8);
        idle(3);
        check("R10 code 0 dropped", 32'(test_mode), 1);

        // R8 / R9: status reply with backpressure
        trig_status = 8'hA5;
        psu_level   = 16'h0C3F;
        idle(1);
        exp_reply = '{8'h03, 8'hA5, 8'h12, 8'h34, 8'hAB, 8'hCD,
                      8'h80, 8'h01, 8'hFF, 8'hFF, 8'h0C, 8'h3F};
        send_byte(8'd2);
        idle(5);
        check("R9 tx_valid held", 32'(tx_valid), 1);
        check("R9 first byte held", 32'(tx_data), 32'h03);
        check("R9 rx stalled", 32'(rx_ready), 0);
        for (int b = 0; b < 12; b++) begin
            tx_ready = 1'b1;
            while (!tx_valid) @(negedge clk);
            got = tx_data;
            check($sformatf("R8 reply byte %0d", b), 32'(got), 32'(exp_reply[b]));
            @(negedge clk);
        end
        tx_ready = 1'b0;
        idle(2);
        check("R9 reply ended", 32'(tx_valid), 0);
        check("R9 rx resumes", 32'(rx_ready), 1);

        // R6: table load, payload bytes are not commands
        send_byte(8'd1);
        for (int i = 0; i < 2048; i++)
            send_byte(8'((i * 7 + 3) & 255));
        idle(4);
        check("R6 write count", 32'(wr_cnt), 2048);
        check("R6 write mismatches", 32'(wr_bad), 0);
        check("R6 load_done", 32'(done_cnt), 1);
        check("R6 i_offset untouched", 32'(i_offset), 32'h1234);
        check("R6 test_mode untouched", 32'(test_mode), 1);
        check("R10 cmd_err still set", 32'(cmd_err), 1);

        finished = 1'b1;
        summary();
    end

endmodule